// File: doc/BRIEF.md
# Sharing-Chain Coherence Directory

This block keeps coherence state for a small set of memory blocks using a chain of caches instead of a full presence map. The home side stores only one entry per block: whether any cache holds it, which cache is at the front of the chain, and whether that front cache holds the block exclusively for writing. Every cache that holds the block keeps two link registers, one toward the older sharers (forward) and one toward the newer sharers or home (backward). Together these links form a chain that can be walked in either direction.

Requests enter as operations: read, write and leave. Each names a requesting node and a block. They are queued and served strictly one at a time in arrival order. For each operation the block emits the sequence of protocol messages, one per cycle, on a message port with source, destination, type and argument fields. It updates the home entry and the link registers as those messages take effect. A read to a held block is answered by home with the identity of the current front cache, not with data, and the requester then fetches the data from that cache. A write walks the chain and invalidates every other sharer. A leave splices the node out of the chain.

A probe port shows the link registers of any node and block and the home entry of any block, so the surrounding model can inspect the coherence state.

Top module: `chain_dir_top`

## Requirements
- R1: After reset, every home entry is empty with exclusive clear, every link entry is invalid with both links holding the null ID, msg_valid is low and busy is low.
- R2: Node IDs are 0..N_NODES-1, home is ID N_NODES and the null ID is all ones. A read (op code 0) by a node when the home entry is empty emits REQ (type 0, requester to home), then DATA (type 3, home to requester). The requester becomes head, with both links null and exclusive clear. Messages without a meaningful argument carry the null ID as argument.
- R3: A read by a non-member when a head H exists emits REQ (requester to home), then PTR (type 1, home to requester, argument H), then FETCH (type 2, requester to H), then DATA (H to requester). Afterwards the requester is head with forward link H and a null backward link, and H's backward link names the requester.
- R4: A read by a node already in the chain for that block emits no message and changes no state.
- R5: Requests that are accepted while earlier ones are pending are served in arrival order, and the message sequence of one request completes before the next one starts.
- R6: A write (op code 1) by the head walks the forward links. For each sharer S it emits INV (type 4, writer to S) and then ACK (type 5, S to writer, argument S's forward link, null at the end). Each acknowledged sharer leaves the chain. The writer ends up alone with a null forward link and exclusive set.
- R7: A write by a non-member first runs the read-join sequence of R2 or R3 and then the invalidation walk of R6.
- R8: A write by a member that is not head first leaves the chain as in R9 to R11, then runs the join of R3, then runs the walk of R6.
- R9: A leave (op code 2) by the head emits UNLINK (type 6, leaver to home, argument its forward neighbour N). If N is not null, it then emits UNLINK (leaver to N, argument null). The home entry then names N, or becomes empty if N is null, and N's backward link becomes null.
- R10: A leave by a middle node with backward neighbour P and forward neighbour N emits UNLINK (leaver to P, argument N), then UNLINK (leaver to N, argument P). P's forward link becomes N, N's backward link becomes P, and the leaver's entry becomes invalid.
- R11: A leave by the last node of a chain of two or more emits a single UNLINK (leaver to its backward neighbour, argument null), and that neighbour's forward link becomes null.
- R12: A leave by a node that is not in the chain emits no message and changes no state.
- R13: A read that joins a block whose head holds it exclusively clears the exclusive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request queue has room |
| req_op | input | 2 | 0 read, 1 write, 2 leave |
| req_node | input | IDW (3) | Requesting node ID |
| req_blk | input | BW (2) | Block index |
| msg_valid | output | 1 | A protocol message is emitted this cycle |
| msg_src | output | IDW (3) | Message source ID |
| msg_dst | output | IDW (3) | Message destination ID |
| msg_type | output | 3 | Message type code |
| msg_arg | output | IDW (3) | Pointer argument of the message |
| busy | output | 1 | Requests queued or in progress |
| probe_node | input | IDW (3) | Node whose link entry is observed |
| probe_blk | input | BW (2) | Block observed |
| probe_lk_vld | output | 1 | Node holds the block |
| probe_fwd | output | IDW (3) | Node's forward link |
| probe_bwd | output | IDW (3) | Node's backward link |
| probe_hd_vld | output | 1 | Home entry of probe_blk is held |
| probe_hd_excl | output | 1 | Head holds probe_blk exclusively |
| probe_hd_id | output | IDW (3) | Head node of probe_blk |

## Verification
The assertions assume that every accepted request names a real node below N_NODES and uses one of the three operation codes. They also assume that nothing outside the engine alters the chain, so the head's backward link is always null and an exclusive head has no forward link. The stimulus uses only node IDs 0 to 3 and codes 0 to 2. Before each operation it waits for busy to fall, except in the ordering test, where two requests are queued on purpose. Every chain shape the bench builds is reached only through legal protocol operations.

// File: rtl/chain_dir_pkg.sv
// Shared encodings for the sharing-chain directory.
// Assumes: message and operation codes are fixed by the protocol and are
// independent of the node and block counts.
package chain_dir_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_LEAVE = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        MSG_REQ    = 3'd0,
        MSG_PTR    = 3'd1,
        MSG_FETCH  = 3'd2,
        MSG_DATA   = 3'd3,
        MSG_INV    = 3'd4,
        MSG_ACK    = 3'd5,
        MSG_UNLINK = 3'd6
    } msg_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_RD_REQ,
        S_RD_MEM,
        S_RD_PTR,
        S_RD_FETCH,
        S_RD_DATA,
        S_INV_CHK,
        S_INV_SEND,
        S_INV_ACK,
        S_LV,
        S_LV2
    } st_e;

endpackage

// File: rtl/chain_req_fifo.sv
// Request queue: holds operations in arrival order until the engine takes them.
// Assumes: push while full and pop while empty are dropped.
module chain_req_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             do_push, do_pop;

    assign empty    = (cnt == '0);
    assign full     = (cnt == (AW+1)'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rp];

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // R5
    fifo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));

    // R5
    fifo_pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && !do_push) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/chain_home_table.sv
// Home table: one entry per block, {held, exclusive, head id}.
// Assumes: a single writer (the engine); two independent combinational reads.
module chain_home_table #(
    parameter int N_BLOCKS = 4,
    parameter int IDW      = 3,
    localparam int BW = $clog2(N_BLOCKS),
    localparam int EW = IDW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] wblk,
    input  logic [EW-1:0] wdata,
    input  logic [BW-1:0] ra_blk,
    output logic [EW-1:0] ra_data,
    input  logic [BW-1:0] rb_blk,
    output logic [EW-1:0] rb_data
);
    localparam logic [IDW-1:0] NIL = '1;

    logic [EW-1:0] ent [N_BLOCKS];

    assign ra_data = ent[ra_blk];
    assign rb_data = ent[rb_blk];

    // Entry update; reset leaves every block with memory as sole holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BLOCKS; b++) ent[b] <= {1'b0, 1'b0, NIL};
        end else if (we) begin
            ent[wblk] <= wdata;
        end
    end

    // R13
    excl_needs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wdata[EW-1] || !wdata[EW-2]));

endmodule

// File: rtl/chain_engine.sv
// Protocol engine: owns the per-node link registers, walks one request at a
// time through join, invalidate and splice sequences, one message per cycle.
// Assumes: request node ids are below N_NODES; home table reads are
// combinational and its write lands on the same edge as link updates.
module chain_engine
    import chain_dir_pkg::*;
#(
    parameter int N_NODES  = 4,
    parameter int N_BLOCKS = 4,
    parameter int IDW      = 3,
    localparam int BW = $clog2(N_BLOCKS),
    localparam int EW = IDW + 2,
    localparam int QW = 2 + IDW + BW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           q_empty,
    input  logic [QW-1:0]  q_data,
    output logic           q_pop,
    input  logic [EW-1:0]  hd_rd,
    output logic [BW-1:0]  hd_rblk,
    output logic           hd_we,
    output logic [EW-1:0]  hd_wd,
    output logic           msg_valid,
    output logic [IDW-1:0] msg_src,
    output logic [IDW-1:0] msg_dst,
    output logic [2:0]     msg_type,
    output logic [IDW-1:0] msg_arg,
    output logic           eng_busy,
    input  logic [IDW-1:0] probe_node,
    input  logic [BW-1:0]  probe_blk,
    output logic           probe_lk_vld,
    output logic [IDW-1:0] probe_fwd,
    output logic [IDW-1:0] probe_bwd
);
    localparam int SPAN = 1 << IDW;
    localparam logic [IDW-1:0] NIL  = '1;
    localparam logic [IDW-1:0] HOME = IDW'(N_NODES);

    logic           lk_vld [SPAN][N_BLOCKS];
    logic [IDW-1:0] lk_fwd [SPAN][N_BLOCKS];
    logic [IDW-1:0] lk_bwd [SPAN][N_BLOCKS];

    st_e            st;
    op_e            cur_op;
    logic [IDW-1:0] cur_node, cursor, aux;
    logic [BW-1:0]  cur_blk;
    logic           then_inv, then_join;

    logic           hd_vld, hd_excl;
    logic [IDW-1:0] hd_id;
    logic           my_vld;
    logic [IDW-1:0] my_fwd, my_bwd, cur_next;

    assign hd_vld   = hd_rd[EW-1];
    assign hd_excl  = hd_rd[EW-2];
    assign hd_id    = hd_rd[IDW-1:0];
    assign hd_rblk  = cur_blk;
    assign my_vld   = lk_vld[cur_node][cur_blk];
    assign my_fwd   = lk_fwd[cur_node][cur_blk];
    assign my_bwd   = lk_bwd[cur_node][cur_blk];
    assign cur_next = lk_fwd[cursor][cur_blk];
    assign q_pop    = (st == S_IDLE) && !q_empty;
    assign eng_busy = (st != S_IDLE);

    assign probe_lk_vld = lk_vld[probe_node][probe_blk];
    assign probe_fwd    = lk_fwd[probe_node][probe_blk];
    assign probe_bwd    = lk_bwd[probe_node][probe_blk];

    // Home entry update, taking effect with the matching link update.
    always_comb begin
        hd_we = 1'b0;
        hd_wd = {1'b0, 1'b0, NIL};
        case (st)
            S_RD_MEM, S_RD_DATA: begin
                hd_we = 1'b1;
                hd_wd = {1'b1, 1'b0, cur_node};
            end
            S_INV_CHK: if (my_fwd == NIL) begin
                hd_we = 1'b1;
                hd_wd = {1'b1, 1'b1, cur_node};
            end
            S_INV_ACK: if (cur_next == NIL) begin
                hd_we = 1'b1;
                hd_wd = {1'b1, 1'b1, cur_node};
            end
            S_LV: if (my_bwd == NIL) begin
                hd_we = 1'b1;
                hd_wd = {my_fwd != NIL, 1'b0, my_fwd};
            end
            default: ;
        endcase
    end

    // Message emitted in the current state.
    always_comb begin
        msg_valid = 1'b1;
        msg_src   = cur_node;
        msg_dst   = HOME;
        msg_type  = MSG_REQ;
        msg_arg   = NIL;
        case (st)
            S_RD_REQ: ;
            S_RD_MEM: begin
                msg_src = HOME; msg_dst = cur_node; msg_type = MSG_DATA;
            end
            S_RD_PTR: begin
                msg_src = HOME; msg_dst = cur_node; msg_type = MSG_PTR; msg_arg = hd_id;
            end
            S_RD_FETCH: begin
                msg_dst = cursor; msg_type = MSG_FETCH;
            end
            S_RD_DATA: begin
                msg_src = cursor; msg_dst = cur_node; msg_type = MSG_DATA;
            end
            S_INV_SEND: begin
                msg_dst = cursor; msg_type = MSG_INV;
            end
            S_INV_ACK: begin
                msg_src = cursor; msg_dst = cur_node; msg_type = MSG_ACK; msg_arg = cur_next;
            end
            S_LV: begin
                msg_dst = (my_bwd == NIL) ? HOME : my_bwd;
                msg_type = MSG_UNLINK; msg_arg = my_fwd;
            end
            S_LV2: begin
                msg_dst = cursor; msg_type = MSG_UNLINK; msg_arg = aux;
            end
            default: msg_valid = 1'b0;
        endcase
    end

    // Sequencer and link register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            cur_op    <= OP_READ;
            cur_node  <= '0;
            cur_blk   <= '0;
            cursor    <= NIL;
            aux       <= NIL;
            then_inv  <= 1'b0;
            then_join <= 1'b0;
            for (int n = 0; n < SPAN; n++) begin
                for (int b = 0; b < N_BLOCKS; b++) begin
                    lk_vld[n][b] <= 1'b0;
                    lk_fwd[n][b] <= NIL;
                    lk_bwd[n][b] <= NIL;
                end
            end
        end else begin
            case (st)
                S_IDLE: if (!q_empty) begin
                    cur_op   <= op_e'(q_data[QW-1 -: 2]);
                    cur_node <= q_data[BW +: IDW];
                    cur_blk  <= q_data[BW-1:0];
                    st       <= S_START;
                end
                S_START: begin
                    then_inv  <= 1'b0;
                    then_join <= 1'b0;
                    case (cur_op)
                        OP_READ:  st <= my_vld ? S_IDLE : S_RD_REQ;
                        OP_WRITE: begin
                            then_inv <= 1'b1;
                            if (!my_vld)           st <= S_RD_REQ;
                            else if (my_bwd == NIL) st <= S_INV_CHK;
                            else begin
                                then_join <= 1'b1;
                                st        <= S_LV;
                            end
                        end
                        OP_LEAVE: st <= my_vld ? S_LV : S_IDLE;
                        default:  st <= S_IDLE;
                    endcase
                end
                S_RD_REQ: st <= hd_vld ? S_RD_PTR : S_RD_MEM;
                S_RD_MEM: begin
                    lk_vld[cur_node][cur_blk] <= 1'b1;
                    lk_fwd[cur_node][cur_blk] <= NIL;
                    lk_bwd[cur_node][cur_blk] <= NIL;
                    st <= then_inv ? S_INV_CHK : S_IDLE;
                end
                S_RD_PTR: begin
                    cursor <= hd_id;
                    st     <= S_RD_FETCH;
                end
                S_RD_FETCH: st <= S_RD_DATA;
                S_RD_DATA: begin
                    lk_vld[cur_node][cur_blk] <= 1'b1;
                    lk_fwd[cur_node][cur_blk] <= cursor;
                    lk_bwd[cur_node][cur_blk] <= NIL;
                    lk_bwd[cursor][cur_blk]   <= cur_node;
                    st <= then_inv ? S_INV_CHK : S_IDLE;
                end
                S_INV_CHK: begin
                    if (my_fwd == NIL) st <= S_IDLE;
                    else begin
                        cursor <= my_fwd;
                        st     <= S_INV_SEND;
                    end
                end
                S_INV_SEND: st <= S_INV_ACK;
                S_INV_ACK: begin
                    lk_vld[cursor][cur_blk] <= 1'b0;
                    lk_fwd[cursor][cur_blk] <= NIL;
                    lk_bwd[cursor][cur_blk] <= NIL;
                    if (cur_next == NIL) begin
                        lk_fwd[cur_node][cur_blk] <= NIL;
                        st <= S_IDLE;
                    end else begin
                        cursor <= cur_next;
                        st     <= S_INV_SEND;
                    end
                end
                S_LV: begin
                    if (my_bwd != NIL) lk_fwd[my_bwd][cur_blk] <= my_fwd;
                    if (my_fwd != NIL) lk_bwd[my_fwd][cur_blk] <= my_bwd;
                    lk_vld[cur_node][cur_blk] <= 1'b0;
                    lk_fwd[cur_node][cur_blk] <= NIL;
                    lk_bwd[cur_node][cur_blk] <= NIL;
                    cursor <= my_fwd;
                    aux    <= my_bwd;
                    if (my_fwd != NIL) st <= S_LV2;
                    else               st <= then_join ? S_RD_REQ : S_IDLE;
                end
                S_LV2: st <= then_join ? S_RD_REQ : S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R3
    head_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hd_vld |-> (lk_vld[hd_id][cur_blk] && lk_bwd[hd_id][cur_blk] == NIL));

    // R6
    excl_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_vld && hd_excl) |-> (lk_fwd[hd_id][cur_blk] == NIL));

    // R6
    inv_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == MSG_INV) |=>
        (msg_valid && msg_type == MSG_ACK && msg_src == $past(msg_dst)));

    // R3
    fetch_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == MSG_FETCH) |=>
        (msg_valid && msg_type == MSG_DATA && msg_src == $past(msg_dst)
         && msg_dst == $past(msg_src)));

    // R2
    msg_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_src != msg_dst));

endmodule

// File: rtl/chain_dir_top.sv
// Sharing-chain directory top: request queue, home table and protocol engine.
// Assumes: req_node below N_NODES, req_op one of the three operation codes,
// N_BLOCKS a power of two of at least 2.
module chain_dir_top #(
    parameter int N_NODES  = 4,
    parameter int N_BLOCKS = 4,
    parameter int Q_DEPTH  = 4,
    localparam int IDW = $clog2(N_NODES + 2),
    localparam int BW  = $clog2(N_BLOCKS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [1:0]     req_op,
    input  logic [IDW-1:0] req_node,
    input  logic [BW-1:0]  req_blk,
    output logic           msg_valid,
    output logic [IDW-1:0] msg_src,
    output logic [IDW-1:0] msg_dst,
    output logic [2:0]     msg_type,
    output logic [IDW-1:0] msg_arg,
    output logic           busy,
    input  logic [IDW-1:0] probe_node,
    input  logic [BW-1:0]  probe_blk,
    output logic           probe_lk_vld,
    output logic [IDW-1:0] probe_fwd,
    output logic [IDW-1:0] probe_bwd,
    output logic           probe_hd_vld,
    output logic           probe_hd_excl,
    output logic [IDW-1:0] probe_hd_id
);
    localparam int QW = 2 + IDW + BW;
    localparam int EW = IDW + 2;

    logic          q_empty, q_full, q_pop, eng_busy;
    logic [QW-1:0] q_data;
    logic [EW-1:0] hd_rd, hd_wd, hd_probe;
    logic [BW-1:0] hd_rblk;
    logic          hd_we;

    assign req_ready     = !q_full;
    assign busy          = !q_empty || eng_busy;
    assign probe_hd_vld  = hd_probe[EW-1];
    assign probe_hd_excl = hd_probe[EW-2];
    assign probe_hd_id   = hd_probe[IDW-1:0];

    chain_req_fifo #(.WIDTH(QW), .DEPTH(Q_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_valid),
        .push_data ({req_op, req_node, req_blk}),
        .pop       (q_pop),
        .pop_data  (q_data),
        .empty     (q_empty),
        .full      (q_full)
    );

    chain_home_table #(.N_BLOCKS(N_BLOCKS), .IDW(IDW)) u_home (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (hd_we),
        .wblk    (hd_rblk),
        .wdata   (hd_wd),
        .ra_blk  (hd_rblk),
        .ra_data (hd_rd),
        .rb_blk  (probe_blk),
        .rb_data (hd_probe)
    );

    chain_engine #(.N_NODES(N_NODES), .N_BLOCKS(N_BLOCKS), .IDW(IDW)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_empty      (q_empty),
        .q_data       (q_data),
        .q_pop        (q_pop),
        .hd_rd        (hd_rd),
        .hd_rblk      (hd_rblk),
        .hd_we        (hd_we),
        .hd_wd        (hd_wd),
        .msg_valid    (msg_valid),
        .msg_src      (msg_src),
        .msg_dst      (msg_dst),
        .msg_type     (msg_type),
        .msg_arg      (msg_arg),
        .eng_busy     (eng_busy),
        .probe_node   (probe_node),
        .probe_blk    (probe_blk),
        .probe_lk_vld (probe_lk_vld),
        .probe_fwd    (probe_fwd),
        .probe_bwd    (probe_bwd)
    );

    // R2
    req_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_node < IDW'(N_NODES) && req_op != 2'd3));

endmodule

// File: tb/chain_dir_top_bench.sv
`timescale 1ns/1ps
module chain_dir_top_bench;
    localparam int IDW = 3;
    localparam int BW  = 2;
    localparam int NIL = 7;
    localparam int HM  = 4;
    localparam int T_REQ = 0, T_PTR = 1, T_FETCH = 2, T_DATA = 3;
    localparam int T_INV = 4, T_ACK = 5, T_UNL = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [1:0]     req_op = '0;
    logic [IDW-1:0] req_node = '0;
    logic [BW-1:0]  req_blk = '0;
    logic           msg_valid;
    logic [IDW-1:0] msg_src, msg_dst, msg_arg;
    logic [2:0]     msg_type;
    logic           busy;
    logic [IDW-1:0] probe_node = '0;
    logic [BW-1:0]  probe_blk = '0;
    logic           probe_lk_vld, probe_hd_vld, probe_hd_excl;
    logic [IDW-1:0] probe_fwd, probe_bwd, probe_hd_id;

    int total = 0;
    int bad = 0;
    int lg_n = 0;
    int lg [64];

    chain_dir_top u_chain_dir_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_node(req_node), .req_blk(req_blk),
        .msg_valid(msg_valid), .msg_src(msg_src), .msg_dst(msg_dst),
        .msg_type(msg_type), .msg_arg(msg_arg), .busy(busy),
        .probe_node(probe_node), .probe_blk(probe_blk),
        .probe_lk_vld(probe_lk_vld), .probe_fwd(probe_fwd), .probe_bwd(probe_bwd),
        .probe_hd_vld(probe_hd_vld), .probe_hd_excl(probe_hd_excl),
        .probe_hd_id(probe_hd_id)
    );

    always #2 clk = ~clk;

    // Message log, packed as src*1000 + dst*100 + type*10 + arg.
    always @(negedge clk) begin
        if (rst_n && msg_valid && lg_n < 64) begin
            lg[lg_n] = int'(msg_src) * 1000 + int'(msg_dst) * 100
                     + int'(msg_type) * 10 + int'(msg_arg);
            lg_n = lg_n + 1;
        end
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic exp_msg(input int i, input int s, input int d, input int t,
                           input int a, input string req);
        if (i >= lg_n) chk_eq(req, lg_n, i + 1);
        else chk_eq(req, lg[i], s * 1000 + d * 100 + t * 10 + a);
    endtask

    task automatic exp_count(input int n, input string req);
        chk_eq(req, lg_n, n);
    endtask

    task automatic chk_link(input int node, input int blk, input int v,
                            input int f, input int b, input string req);
        probe_node = IDW'(node);
        probe_blk  = BW'(blk);
        #1;
        chk_eq(req, int'(probe_lk_vld) * 100 + int'(probe_fwd) * 10 + int'(probe_bwd),
               v * 100 + f * 10 + b);
    endtask

    task automatic chk_home(input int blk, input int v, input int x, input int id,
                            input string req);
        probe_blk = BW'(blk);
        #1;
        chk_eq(req, int'(probe_hd_vld) * 100 + int'(probe_hd_excl) * 10
                  + (probe_hd_vld ? int'(probe_hd_id) : 0), v * 100 + x * 10 + id);
    endtask

    task automatic send(input int op, input int node, input int blk);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_node  = IDW'(node);
        req_blk   = BW'(blk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run(input int op, input int node, input int blk);
        lg_n = 0;
        send(op, node, blk);
        wait_idle();
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        chk_eq("R1 busy", int'(busy), 0);
        chk_eq("R1 msg_valid", int'(msg_valid), 0);
        chk_home(0, 0, 0, 0, "R1 home0");
        chk_home(3, 0, 0, 0, "R1 home3");
        chk_link(0, 0, 0, NIL, NIL, "R1 link n0b0");
        chk_link(3, 2, 0, NIL, NIL, "R1 link n3b2");
    endtask

    // R2: read of a block held only by memory
    task automatic t_read_empty();
        run(0, 2, 0);
        exp_count(2, "R2 count");
        exp_msg(0, 2, HM, T_REQ, NIL, "R2 req");
        exp_msg(1, HM, 2, T_DATA, NIL, "R2 data");
        chk_home(0, 1, 0, 2, "R2 head");
        chk_link(2, 0, 1, NIL, NIL, "R2 link");
    endtask

    // R3: read joins in front of the current head
    task automatic t_read_chain();
        run(0, 0, 0);
        exp_count(4, "R3 count");
        exp_msg(0, 0, HM, T_REQ, NIL, "R3 req");
        exp_msg(1, HM, 0, T_PTR, 2, "R3 ptr");
        exp_msg(2, 0, 2, T_FETCH, NIL, "R3 fetch");
        exp_msg(3, 2, 0, T_DATA, NIL, "R3 data");
        chk_home(0, 1, 0, 0, "R3 head");
        chk_link(0, 0, 1, 2, NIL, "R3 new head links");
        chk_link(2, 0, 1, NIL, 0, "R3 old head bwd");
    endtask

    // R4: read by an existing member is silent
    task automatic t_hit();
        run(0, 2, 0);
        exp_count(0, "R4 count");
        chk_home(0, 1, 0, 0, "R4 head");
        chk_link(2, 0, 1, NIL, 0, "R4 link");
    endtask

    // R5: two queued reads are served in arrival order
    task automatic t_fifo();
        lg_n = 0;
        send(0, 1, 0);
        send(0, 3, 0);
        wait_idle();
        exp_count(8, "R5 count");
        exp_msg(0, 1, HM, T_REQ, NIL, "R5 first req");
        exp_msg(1, HM, 1, T_PTR, 0, "R5 first ptr");
        exp_msg(3, 0, 1, T_DATA, NIL, "R5 first data");
        exp_msg(4, 3, HM, T_REQ, NIL, "R5 second req");
        exp_msg(5, HM, 3, T_PTR, 1, "R5 second ptr");
        exp_msg(6, 3, 1, T_FETCH, NIL, "R5 second fetch");
        chk_home(0, 1, 0, 3, "R5 head");
        chk_link(1, 0, 1, 0, 3, "R5 middle links");
    endtask

    // R10: middle node leaves (chain 3->1->0->2)
    task automatic t_leave_mid();
        run(2, 1, 0);
        exp_count(2, "R10 count");
        exp_msg(0, 1, 3, T_UNL, 0, "R10 to prev");
        exp_msg(1, 1, 0, T_UNL, 3, "R10 to next");
        chk_link(3, 0, 1, 0, NIL, "R10 prev fwd");
        chk_link(0, 0, 1, 2, 3, "R10 next bwd");
        chk_link(1, 0, 0, NIL, NIL, "R10 leaver");
    endtask

    // R11: last node leaves (chain 3->0->2)
    task automatic t_leave_tail();
        run(2, 2, 0);
        exp_count(1, "R11 count");
        exp_msg(0, 2, 0, T_UNL, NIL, "R11 unlink");
        chk_link(0, 0, 1, NIL, 3, "R11 new tail");
        chk_link(2, 0, 0, NIL, NIL, "R11 leaver");
    endtask

    // R9: head leaves (chain 3->0)
    task automatic t_leave_head();
        run(2, 3, 0);
        exp_count(2, "R9 count");
        exp_msg(0, 3, HM, T_UNL, 0, "R9 to home");
        exp_msg(1, 3, 0, T_UNL, NIL, "R9 to next");
        chk_home(0, 1, 0, 0, "R9 head");
        chk_link(0, 0, 1, NIL, NIL, "R9 new head links");
    endtask

    // R12: leave by a non-member does nothing
    task automatic t_ignore();
        run(2, 3, 0);
        exp_count(0, "R12 count");
        chk_home(0, 1, 0, 0, "R12 head");
        chk_link(3, 0, 0, NIL, NIL, "R12 link");
    endtask

    // R6: head write invalidates the chain 2->1->0
    task automatic t_write_head();
        run(0, 1, 0);
        run(0, 2, 0);
        chk_home(0, 1, 0, 2, "R6 setup head");
        run(1, 2, 0);
        exp_count(4, "R6 count");
        exp_msg(0, 2, 1, T_INV, NIL, "R6 inv1");
        exp_msg(1, 1, 2, T_ACK, 0, "R6 ack1");
        exp_msg(2, 2, 0, T_INV, NIL, "R6 inv0");
        exp_msg(3, 0, 2, T_ACK, NIL, "R6 ack0");
        chk_home(0, 1, 1, 2, "R6 excl head");
        chk_link(2, 0, 1, NIL, NIL, "R6 writer links");
        chk_link(1, 0, 0, NIL, NIL, "R6 n1 gone");
        chk_link(0, 0, 0, NIL, NIL, "R6 n0 gone");
    endtask

    // R7: write by a non-member joins then invalidates
    task automatic t_write_join();
        run(1, 3, 0);
        exp_count(6, "R7 count");
        exp_msg(1, HM, 3, T_PTR, 2, "R7 ptr");
        exp_msg(3, 2, 3, T_DATA, NIL, "R7 data");
        exp_msg(4, 3, 2, T_INV, NIL, "R7 inv");
        exp_msg(5, 2, 3, T_ACK, NIL, "R7 ack");
        chk_home(0, 1, 1, 3, "R7 excl head");
        chk_link(2, 0, 0, NIL, NIL, "R7 old gone");
    endtask

    // R13: read of an exclusively held block clears exclusive
    task automatic t_read_excl();
        run(0, 0, 0);
        exp_count(4, "R13 count");
        exp_msg(1, HM, 0, T_PTR, 3, "R13 ptr");
        chk_home(0, 1, 0, 0, "R13 excl cleared");
        chk_link(3, 0, 1, NIL, 0, "R13 old head bwd");
    endtask

    // R8: write by a non-head member (chain 0->3, writer 3)
    task automatic t_write_mid();
        run(1, 3, 0);
        exp_count(7, "R8 count");
        exp_msg(0, 3, 0, T_UNL, NIL, "R8 unlink");
        exp_msg(1, 3, HM, T_REQ, NIL, "R8 req");
        exp_msg(2, HM, 3, T_PTR, 0, "R8 ptr");
        exp_msg(3, 3, 0, T_FETCH, NIL, "R8 fetch");
        exp_msg(4, 0, 3, T_DATA, NIL, "R8 data");
        exp_msg(5, 3, 0, T_INV, NIL, "R8 inv");
        exp_msg(6, 0, 3, T_ACK, NIL, "R8 ack");
        chk_home(0, 1, 1, 3, "R8 excl head");
        chk_link(0, 0, 0, NIL, NIL, "R8 n0 gone");
    endtask

    // R9: sole holder leaves, memory again holds the only copy
    task automatic t_leave_alone();
        run(2, 3, 0);
        exp_count(1, "R9 alone count");
        exp_msg(0, 3, HM, T_UNL, NIL, "R9 alone unlink");
        chk_home(0, 0, 0, 0, "R9 alone home");
        run(0, 1, 2);
        exp_msg(1, HM, 1, T_DATA, NIL, "R2 other block data");
        chk_home(2, 1, 0, 1, "R2 other block head");
        chk_home(1, 0, 0, 0, "R1 untouched block");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_empty();
        t_read_chain();
        t_hit();
        t_fifo();
        t_leave_mid();
        t_leave_tail();
        t_leave_head();
        t_ignore();
        t_write_head();
        t_write_join();
        t_read_excl();
        t_write_mid();
        t_leave_alone();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule